// File: doc/BRIEF.md
# Character-Cell Video Generator

This block builds a character-mode picture, 288 pixels by 240 lines by default, out of two tables kept in external memory that other masters also use. A name table holds one tile number for each 8x8 screen cell, stored row after row. A tile table holds each tile's bitmap as eight consecutive bytes, one byte per pixel row, at one bit per pixel. The block runs on a master clock and moves on by one pixel every fourth master cycle. Each pixel comes out as a foreground or background colour code, qualified by a valid pulse and marked by line and frame strobes, ready for a downstream scaler.

Memory is reached through a request/acknowledge port on a shared arbiter whose latency varies. While one cell is being shown, the block reads the next cell's tile number and then that tile's bitmap row into a one-cell buffer. The picture therefore stays clean as long as both reads finish within one cell time. At that limit the bitmap byte arrives in the very cycle the cell's output begins, and it is passed straight to the pixel shifter.

Top module: `tile_video_gen`

## Requirements
- R1: While reset is high, `mem_req`, `pix_valid`, `line_start` and `frame_start` are all 0.
- R2: `pix_valid` pulses for one master cycle, exactly 4 master cycles apart within a line. Each line has H_ACT pulses and each frame has V_ACT lines.
- R3: The tile number for pixel (x, y) is read from word address NAME_BASE + (y/8)*(H_ACT/8) + x/8. NAME_BASE defaults to 0xA000.
- R4: The bitmap byte for pixel (x, y) is read from TILE_BASE + tile*8 + (y mod 8), where tile is the byte returned by the name read. TILE_BASE defaults to 0xA800.
- R5: Bit 7 of a bitmap byte is the leftmost pixel of the cell and bit 0 the rightmost. A 1 bit outputs FG_COLOR and a 0 bit outputs BG_COLOR on `pix_color`.
- R6: Once `mem_req` rises it stays high, with `mem_addr` unchanged, until a cycle in which `mem_ack` is 1. There is never more than one read in flight.
- R7: `line_start` is 1 only together with the first `pix_valid` of each line. `frame_start` is 1 only together with the first `pix_valid` of line 0, and `line_start` is also 1 in that cycle.
- R8: Reads follow raster order. For every line, cells 0 to H_ACT/8-1 are read in turn, each as a name read followed by a bitmap read. After line V_ACT-1 the sequence continues with line 0.
- R9: Every pixel is correct when, for each cell, the time `mem_req` is held high across its two reads totals at most 31 master cycles. At that limit the bitmap answer lands in the cycle the cell's first pixel is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Read request to the memory arbiter |
| mem_addr | output | AW | Word address of the read |
| mem_ack | input | 1 | One-cycle acknowledge; `mem_rdata` is valid in this cycle |
| mem_rdata | input | DW | Read data |
| pix_valid | output | 1 | One-cycle pixel strobe |
| pix_color | output | COLOR_W | Colour code of the current pixel |
| line_start | output | 1 | Marks the first pixel of a line |
| frame_start | output | 1 | Marks the first pixel of a frame |

## Verification
The bitmap answer for the next cell can arrive in the same master cycle that the pixel shifter reloads for that cell. In that cycle the prefetch buffer is empty, and the byte has to be forwarded straight from `mem_rdata` and must not be left stale in the buffer. The bench's memory model lets the delay of each read be set. It uses a name delay of 14 and a bitmap delay of 16 to hit that cycle exactly, and one cycle less to land just before it. Every pixel of the frame is then compared with the colour computed from the table formulas.

// File: rtl/tvg_pkg.sv
package tvg_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_NAME = 2'd1,
    FS_BMP  = 2'd2
  } fetch_st_e;

  localparam int unsigned TILE_PX  = 8;
  localparam int unsigned PIX_DIV  = 4;
endpackage

// File: rtl/tvg_raster.sv
module tvg_raster #(
  parameter int unsigned H_ACT   = 288,
  parameter int unsigned H_TOTAL = 342,
  parameter int unsigned V_ACT   = 240,
  parameter int unsigned V_TOTAL = 262,
  parameter int unsigned HW      = 9,
  parameter int unsigned VW      = 9
) (
  input  logic          clk,
  input  logic          rst,
  output logic          pix_en,
  output logic          active,
  output logic          load,
  output logic          line_first,
  output logic          frame_first,
  output logic [HW-4:0] col,
  output logic [VW-1:0] line
);
  logic [1:0]    div_q;
  logic [HW-1:0] hpos;
  logic [VW-1:0] vpos;

  // start in the last blanking line so the first cell is prefetched in time
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= 2'd0;
      hpos  <= '0;
      vpos  <= VW'(V_TOTAL-1);
    end else begin
      div_q <= div_q + 2'd1;
      if (pix_en) begin
        if (hpos == HW'(H_TOTAL-1)) begin
          hpos <= '0;
          vpos <= (vpos == VW'(V_TOTAL-1)) ? '0 : vpos + 1'b1;
        end else begin
          hpos <= hpos + 1'b1;
        end
      end
    end
  end

  always_comb begin
    pix_en      = (div_q == 2'd3);
    active      = (hpos < HW'(H_ACT)) && (vpos < VW'(V_ACT));
    load        = pix_en && active && (hpos[2:0] == 3'd0);
    line_first  = (hpos == '0);
    frame_first = (hpos == '0) && (vpos == '0);
    col         = hpos[HW-1:3];
    line        = vpos;
  end

  // R2
  pix_en_gap_chk: assert property (@(posedge clk) disable iff (rst)
    pix_en |=> !pix_en);
  // R2
  pix_en_period_chk: assert property (@(posedge clk) disable iff (rst)
    $past(pix_en, 4) |-> pix_en);
endmodule

// File: rtl/tvg_fetch.sv
module tvg_fetch
  import tvg_pkg::*;
#(
  parameter int unsigned COLS      = 36,
  parameter int unsigned ROWS      = 30,
  parameter int unsigned V_ACT     = 240,
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 8,
  parameter int unsigned HW        = 9,
  parameter int unsigned VW        = 9,
  parameter int unsigned NAME_BASE = 'hA000,
  parameter int unsigned TILE_BASE = 'hA800
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [HW-4:0] col,
  input  logic [VW-1:0] line,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic [7:0]    buf_byte,
  output logic          buf_vld,
  output logic          fwd,
  output logic [7:0]    fwd_byte
);
  localparam int unsigned CLW = HW - 3;
  localparam int unsigned CW  = (COLS > 1) ? $clog2(COLS) : 1;

  fetch_st_e     st;
  logic [VW-1:0] tgt_line;
  logic [CW-1:0] tgt_col;
  logic [AW-1:0] name_addr;
  logic [AW-1:0] bmp_addr;

  always_comb begin
    name_addr = AW'(NAME_BASE) + AW'(tgt_line >> 3) * AW'(COLS) + AW'(tgt_col);
    bmp_addr  = AW'(TILE_BASE) + (AW'(mem_rdata) << 3) + AW'(tgt_line[2:0]);
    fwd       = (st == FS_BMP) && mem_ack;
    fwd_byte  = mem_rdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FS_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      buf_byte <= '0;
      buf_vld  <= 1'b0;
      tgt_line <= '0;
      tgt_col  <= '0;
    end else begin
      if (load) begin
        buf_vld <= 1'b0;
        if (col == CLW'(COLS-1)) begin
          tgt_col  <= '0;
          tgt_line <= (line == VW'(V_ACT-1)) ? '0 : line + 1'b1;
        end else begin
          tgt_col  <= CW'(col) + 1'b1;
          tgt_line <= line;
        end
      end
      case (st)
        FS_IDLE: if (!buf_vld && !load) begin
          st       <= FS_NAME;
          mem_req  <= 1'b1;
          mem_addr <= name_addr;
        end
        FS_NAME: if (mem_ack) begin
          st       <= FS_BMP;
          mem_addr <= bmp_addr;
        end
        FS_BMP: if (mem_ack) begin
          st      <= FS_IDLE;
          mem_req <= 1'b0;
          // when the shifter reloads now it takes the byte directly
          if (!load) begin
            buf_byte <= mem_rdata[7:0];
            buf_vld  <= 1'b1;
          end
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  // R3 R4
  addr_window_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |->
      ((mem_addr >= AW'(NAME_BASE)) && (mem_addr < AW'(NAME_BASE + COLS*ROWS))) ||
      ((mem_addr >= AW'(TILE_BASE)) && (mem_addr < AW'(TILE_BASE + (2**DW)*8))));
endmodule

// File: rtl/tvg_shift.sv
module tvg_shift #(
  parameter int unsigned COLOR_W  = 4,
  parameter int unsigned FG_COLOR = 15,
  parameter int unsigned BG_COLOR = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_en,
  input  logic               active,
  input  logic               load,
  input  logic               line_first,
  input  logic               frame_first,
  input  logic [7:0]         buf_byte,
  input  logic               buf_vld,
  input  logic               fwd,
  input  logic [7:0]         fwd_byte,
  output logic               pix_valid,
  output logic [COLOR_W-1:0] pix_color,
  output logic               line_start,
  output logic               frame_start
);
  logic [7:0] sh_q;
  logic [7:0] cur;

  always_comb begin
    if (load) cur = buf_vld ? buf_byte : (fwd ? fwd_byte : 8'h00);
    else      cur = sh_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q        <= '0;
      pix_valid   <= 1'b0;
      pix_color   <= '0;
      line_start  <= 1'b0;
      frame_start <= 1'b0;
    end else if (pix_en && active) begin
      sh_q        <= {cur[6:0], 1'b0};
      pix_color   <= cur[7] ? COLOR_W'(FG_COLOR) : COLOR_W'(BG_COLOR);
      pix_valid   <= 1'b1;
      line_start  <= line_first;
      frame_start <= frame_first;
    end else begin
      pix_valid   <= 1'b0;
      line_start  <= 1'b0;
      frame_start <= 1'b0;
    end
  end

  // R2
  valid_gap_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> !pix_valid);
  // R7
  line_valid_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |-> pix_valid);
  // R7
  frame_line_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line_start && pix_valid);
endmodule

// File: rtl/tile_video_gen.sv
module tile_video_gen #(
  parameter int unsigned H_ACT     = 288,
  parameter int unsigned H_TOTAL   = 342,
  parameter int unsigned V_ACT     = 240,
  parameter int unsigned V_TOTAL   = 262,
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 8,
  parameter int unsigned COLOR_W   = 4,
  parameter int unsigned FG_COLOR  = 15,
  parameter int unsigned BG_COLOR  = 0,
  parameter int unsigned NAME_BASE = 'hA000,
  parameter int unsigned TILE_BASE = 'hA800
) (
  input  logic               clk,
  input  logic               rst,
  output logic               mem_req,
  output logic [AW-1:0]      mem_addr,
  input  logic               mem_ack,
  input  logic [DW-1:0]      mem_rdata,
  output logic               pix_valid,
  output logic [COLOR_W-1:0] pix_color,
  output logic               line_start,
  output logic               frame_start
);
  localparam int unsigned COLS = H_ACT / 8;
  localparam int unsigned ROWS = (V_ACT + 7) / 8;
  localparam int unsigned HW   = $clog2(H_TOTAL);
  localparam int unsigned VW   = $clog2(V_TOTAL);

  logic          pix_en, active, load, line_first, frame_first;
  logic [HW-4:0] col;
  logic [VW-1:0] line;
  logic [7:0]    buf_byte, fwd_byte;
  logic          buf_vld, fwd;

  tvg_raster #(
    .H_ACT(H_ACT), .H_TOTAL(H_TOTAL), .V_ACT(V_ACT), .V_TOTAL(V_TOTAL),
    .HW(HW), .VW(VW)
  ) u_raster (
    .clk(clk), .rst(rst), .pix_en(pix_en), .active(active), .load(load),
    .line_first(line_first), .frame_first(frame_first), .col(col), .line(line)
  );

  tvg_fetch #(
    .COLS(COLS), .ROWS(ROWS), .V_ACT(V_ACT), .AW(AW), .DW(DW), .HW(HW), .VW(VW),
    .NAME_BASE(NAME_BASE), .TILE_BASE(TILE_BASE)
  ) u_fetch (
    .clk(clk), .rst(rst), .load(load), .col(col), .line(line),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .buf_byte(buf_byte), .buf_vld(buf_vld), .fwd(fwd), .fwd_byte(fwd_byte)
  );

  tvg_shift #(
    .COLOR_W(COLOR_W), .FG_COLOR(FG_COLOR), .BG_COLOR(BG_COLOR)
  ) u_shift (
    .clk(clk), .rst(rst), .pix_en(pix_en), .active(active), .load(load),
    .line_first(line_first), .frame_first(frame_first),
    .buf_byte(buf_byte), .buf_vld(buf_vld), .fwd(fwd), .fwd_byte(fwd_byte),
    .pix_valid(pix_valid), .pix_color(pix_color),
    .line_start(line_start), .frame_start(frame_start)
  );
endmodule

// File: tb/test_tile_video_gen.sv
`timescale 1ns/1ps
module test_tile_video_gen;
  localparam int H_ACT = 32, H_TOTAL = 48, V_ACT = 24, V_TOTAL = 26;
  localparam int COLS = H_ACT / 8;
  localparam int FG = 10, BG = 5;

  logic       clk = 0;
  logic       rst = 1;
  logic       mem_req, mem_ack = 0;
  logic [15:0] mem_addr;
  logic [7:0] mem_rdata = 0;
  logic       pix_valid, line_start, frame_start;
  logic [3:0] pix_color;

  tile_video_gen #(
    .H_ACT(H_ACT), .H_TOTAL(H_TOTAL), .V_ACT(V_ACT), .V_TOTAL(V_TOTAL),
    .FG_COLOR(FG), .BG_COLOR(BG)
  ) i_tile_video_gen (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .pix_valid(pix_valid),
    .pix_color(pix_color), .line_start(line_start), .frame_start(frame_start)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0;
  int mseed = 0, pseed = 0, d1 = 1, d2 = 1;
  int nseed = 0, nd1 = 1, nd2 = 1;
  int sw_count = 0, fcount = 0;
  int frm_px = 0, frm_ln = 0, px_cnt = 0, ln_cnt = 0;
  bit started = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int tile_of(input int idx, input int seed);
    return (idx * 37 + seed * 59 + 11) % 256;
  endfunction

  function automatic int bmp_of(input int t, input int r, input int seed);
    return ((t * 73) ^ (r * 151) ^ (seed * 29) ^ (t >> 2)) & 255;
  endfunction

  function automatic int exp_color(input int x, input int y, input int seed);
    int t, b;
    t = tile_of((y / 8) * COLS + x / 8, seed);
    b = bmp_of(t, y % 8, seed);
    return b[7 - (x % 8)] ? FG : BG;
  endfunction

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // memory model: answers after d1 (name) or d2 (bitmap) counted cycles
  initial begin
    int cnt = 0, ph = 0, ly = 0, lc = 0, ea, a;
    forever begin
      @(negedge clk);
      if (rst) begin
        mem_ack = 0; cnt = 0;
      end else if (mem_ack) begin
        mem_ack = 0; cnt = 0;
      end else if (mem_req) begin
        cnt++;
        if (cnt >= ((ph == 0) ? d1 : d2)) begin
          a = int'(mem_addr);
          if (ph == 0) begin
            ea = 'hA000 + (ly / 8) * COLS + lc;
            chk(a == ea, "R3/R8 name address", a, ea);
            mem_rdata = 8'(tile_of(a - 'hA000, mseed));
            ph = 1;
          end else begin
            ea = 'hA800 + tile_of((ly / 8) * COLS + lc, mseed) * 8 + ly % 8;
            chk(a == ea, "R4/R8 bitmap address", a, ea);
            mem_rdata = 8'(bmp_of((a - 'hA800) >> 3, a % 8, mseed));
            ph = 0;
            if (lc == COLS - 1) begin
              lc = 0;
              ly = (ly == V_ACT - 1) ? 0 : ly + 1;
            end else lc++;
          end
          mem_ack = 1; cnt = 0;
        end
      end else if (cnt != 0) begin
        chk(0, "R6 req dropped before ack", 0, 1);
        cnt = 0;
      end
    end
  end

  // output monitor
  initial begin
    int x = 0, y = 0, last_pv = 0, e;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (pix_valid && !started && !frame_start)
          chk(0, "R7 pixel before first frame strobe", 1, 0);
        if (frame_start) begin
          chk(line_start == 1'b1, "R7 frame strobe with line strobe", int'(line_start), 1);
          if (started) begin frm_px = px_cnt; frm_ln = ln_cnt; end
          started = 1; fcount++; pseed = mseed;
          x = 0; y = 0; px_cnt = 0; ln_cnt = 1;
        end else if (line_start) begin
          chk(x == H_ACT, "R2 pixels in previous line", x, H_ACT);
          chk(y + 1 < V_ACT, "R7 line strobe inside frame", y + 1, V_ACT - 1);
          x = 0; y++; ln_cnt++;
        end
        if (line_start) chk(pix_valid == 1'b1, "R7 line strobe with pixel", int'(pix_valid), 1);
        if (pix_valid && started) begin
          if (x != 0) chk(cyc - last_pv == 4, "R2 pixel spacing", cyc - last_pv, 4);
          last_pv = cyc;
          e = exp_color(x, y, pseed);
          chk(int'(pix_color) == e, "R5/R9 pixel colour", int'(pix_color), e);
          if (x == H_ACT - 8 && y == V_ACT - 1) begin
            mseed = nseed; d1 = nd1; d2 = nd2; sw_count++;
          end
          x++; px_cnt++;
        end
      end
    end
  end

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(mem_req == 0, "R1 req in reset", int'(mem_req), 0);
    chk(pix_valid == 0, "R1 pix_valid in reset", int'(pix_valid), 0);
    chk(line_start == 0, "R1 line_start in reset", int'(line_start), 0);
    chk(frame_start == 0, "R1 frame_start in reset", int'(frame_start), 0);
    rst = 0;
  endtask

  task automatic run_frame(input int seed, input int a, input int b, input string tag);
    int s0, f0, b0;
    nseed = seed; nd1 = a; nd2 = b;
    s0 = sw_count;
    wait (sw_count > s0);
    f0 = fcount; b0 = bad;
    wait (fcount >= f0 + 2);
    @(negedge clk);
    chk(frm_px == H_ACT * V_ACT, {"R2 pixels per frame ", tag}, frm_px, H_ACT * V_ACT);
    chk(frm_ln == V_ACT, {"R2 lines per frame ", tag}, frm_ln, V_ACT);
    chk(bad == b0, {"R9 clean frame ", tag}, bad - b0, 0);
  endtask

  task automatic t_fast_mem;     run_frame(1, 1, 1, "fast");          endtask
  task automatic t_slow_mem;     run_frame(2, 9, 12, "slow");         endtask
  task automatic t_uneven;       run_frame(3, 20, 2, "uneven");       endtask
  task automatic t_limit_early;  run_frame(4, 14, 15, "limit-1");     endtask
  task automatic t_limit_same;   run_frame(5, 14, 16, "same-cycle");  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R2: actual=hang expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fast_mem();
    t_slow_mem();
    t_uneven();
    t_limit_early();
    t_limit_same();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule